// File: doc/BRIEF.md
# Pseudo-Random Generator and Byte-Order Reverser Peripheral

This peripheral sits on a simple 32-bit register bus. It has a 32-bit pseudo-random generator built as a Galois linear feedback shift register, which software seeds. It also has a helper that reverses byte order across one 32-bit word or across a 64-bit pair. One shared address does two jobs: a write loads a new seed, and a read returns the generator's present state. A control register picks how the generator advances. It can step on every clock, or it can step only after a read of its address.

Software loads eight bytes through two write-buffer words. It then reads the reversed bytes back from two read-buffer words. Two read-only words pass through the values from external true-random sources. The enable bit and the speed bit for those sources are driven straight out of the control register.

The bus is combinational on reads. `bus_rdata` is valid in the same cycle that `bus_rd` is high. Writes take effect at the rising edge.

Top module: `rng_swap_periph`

## Requirements
- R1: While reset is held, and after a synchronous active-low reset, the control register and both write buffers read zero. The generator holds 0x5EED0001.
- R2: One generator step maps state s to (s >> 1), XORed with 0x80200003 when bit 0 of s is 1.
- R3: When control bit 0 is 0, the generator advances one step at every rising clock edge.
- R4: When control bit 0 is 1, the generator advances only at the edge that ends a read of word offset 0x00. That read returns the value held before the step. Reads of other offsets and idle cycles leave the state unchanged.
- R5: A write to offset 0x00 loads the written value into the generator. This load wins over a step in the same cycle.
- R6: A write of zero to offset 0x00 loads 0x5EED0001 instead.
- R7: The control register at offset 0x04 keeps bits [5:0] and reads them back. Bits [31:6] always read zero.
- R8: `meta_fast_o` follows control bit 2, `noise_en_o` follows control bit 3, and `meta_en_o` follows control bit 4.
- R9: The write buffers at 0x08 and 0x0C read back the last value written. Byte 0 is bits [7:0] of 0x08 and byte 4 is bits [7:0] of 0x0C.
- R10: The word at 0x14 returns bytes 3,2,1,0 in bits [7:0],[15:8],[23:16],[31:24]. The word at 0x10 returns the same order when control bit 1 is 0.
- R11: When control bit 1 is 1, the word at 0x10 returns bytes 7,6,5,4 in bits [7:0],[15:8],[23:16],[31:24].
- R12: Offset 0x18 reads `meta_val_i` and offset 0x1C reads `noise_val_i`. Writes to 0x10, 0x14, 0x18 and 0x1C change no register.
- R13: Reads of word offsets 0x20 to 0x3C return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 6 | Byte address; bits [1:0] are ignored |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data; zero when bus_rd is low |
| meta_val_i | input | 32 | Value from the metastable-latch entropy source |
| noise_val_i | input | 32 | Value from the white-noise entropy source |
| meta_fast_o | output | 1 | Speed select for the metastable source (1 = fast) |
| noise_en_o | output | 1 | White-noise source enable |
| meta_en_o | output | 1 | Metastable source enable |

## Verification
The assertions assume that strobes and the address are stable across each clock edge. They also assume that a read in read-advance mode is counted once for each edge during which `bus_rd` stays high at offset 0x00. The bench drives every input on the falling edge and holds each strobe for exactly one rising edge, so each transaction covers exactly one step decision. The entropy inputs are changed only between transactions, which keeps the pass-through checks free of races.

// File: rtl/rsw_pkg.sv
// Package: shared constants and types for the random/byte-swap peripheral.
// Assumes a 32-bit data path; word offsets are bus_addr[ADDR_W-1:2].
package rsw_pkg;
    localparam int DATA_W  = 32;
    localparam int CTRL_W  = 6;
    localparam int IDX_W   = 4;

    // Word indices of the mapped registers (byte offset / 4)
    localparam logic [IDX_W-1:0] IDX_RAND  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_CTRL  = 4'd1;
    localparam logic [IDX_W-1:0] IDX_WLO   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_WHI   = 4'd3;
    localparam logic [IDX_W-1:0] IDX_RLO   = 4'd4;
    localparam logic [IDX_W-1:0] IDX_RHI   = 4'd5;
    localparam logic [IDX_W-1:0] IDX_META  = 4'd6;
    localparam logic [IDX_W-1:0] IDX_NOISE = 4'd7;

    localparam logic [DATA_W-1:0] SEED_FALLBACK = 32'h5EED_0001;
    localparam logic [DATA_W-1:0] TAP_MASK      = 32'h8020_0003;

    // Control fields; first member is the MSB (bit 5)
    typedef struct packed {
        logic spare;
        logic meta_en;
        logic noise_en;
        logic meta_fast;
        logic swap64;
        logic step_on_read;
    } ctrl_t;
endpackage

// File: rtl/rsw_lfsr.sv
// Module: Galois LFSR with a seed load.
// Assumes: load has priority over step; a zero load value is replaced
// by FALLBACK so the state never becomes all zeros.
module rsw_lfsr #(
    parameter int              W        = 32,
    parameter logic [W-1:0]    MASK     = 32'h8020_0003,
    parameter logic [W-1:0]    FALLBACK = 32'h5EED_0001
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] state
);
    logic [W-1:0] state_q;
    logic [W-1:0] stepped;
    logic [W-1:0] seed_eff;

    // Purpose: next value after one Galois shift
    always_comb begin
        stepped = (state_q >> 1) ^ (state_q[0] ? MASK : '0);
    end

    // Purpose: substitute the fallback constant for a zero seed
    always_comb begin
        seed_eff = (load_val == '0) ? FALLBACK : load_val;
    end

    // Purpose: state register with load-over-step priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= FALLBACK;
        else if (load)
            state_q <= seed_eff;
        else if (step)
            state_q <= stepped;
    end

    assign state = state_q;
endmodule

// File: rtl/rsw_swap.sv
// Module: byte-order reverser over a two-word buffer.
// Assumes W is a multiple of 8. rd_hi is always the lower word reversed;
// rd_lo is the lower word reversed, or the upper word reversed when swap64.
module rsw_swap #(
    parameter int W = 32
) (
    input  logic [W-1:0] wr_lo,
    input  logic [W-1:0] wr_hi,
    input  logic         swap64,
    output logic [W-1:0] rd_lo,
    output logic [W-1:0] rd_hi
);
    localparam int NB = W / 8;

    logic [W-1:0] rev_lo;
    logic [W-1:0] rev_hi;

    // Purpose: reverse byte lanes of each buffer word
    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign rev_lo[8*b +: 8] = wr_lo[8*(NB-1-b) +: 8];
        assign rev_hi[8*b +: 8] = wr_hi[8*(NB-1-b) +: 8];
    end

    // Purpose: choose single-word or paired reversal for the lower read word
    always_comb begin
        rd_lo = swap64 ? rev_hi : rev_lo;
        rd_hi = rev_lo;
    end
endmodule

// File: rtl/rsw_regs.sv
// Module: address decode, writable registers and read multiplexer.
// Assumes one-cycle strobes; reads are combinational and return zero
// when bus_rd is low or the offset is unmapped.
module rsw_regs
    import rsw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] lfsr_state,
    input  logic [DATA_W-1:0] swap_lo,
    input  logic [DATA_W-1:0] swap_hi,
    input  logic [DATA_W-1:0] meta_val,
    input  logic [DATA_W-1:0] noise_val,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] wbuf_lo,
    output logic [DATA_W-1:0] wbuf_hi,
    output logic              seed_load,
    output logic              rand_read
);
    localparam int WIDX_W = ADDR_W - 2;

    logic [WIDX_W-1:0] widx;
    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] wlo_q;
    logic [DATA_W-1:0] whi_q;

    assign widx = bus_addr[ADDR_W-1:2];

    // Purpose: strobes toward the generator
    always_comb begin
        seed_load = bus_wr && (widx == WIDX_W'(IDX_RAND));
        rand_read = bus_rd && (widx == WIDX_W'(IDX_RAND));
    end

    // Purpose: control and write-buffer registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            wlo_q  <= '0;
            whi_q  <= '0;
        end else if (bus_wr) begin
            if (widx == WIDX_W'(IDX_CTRL)) ctrl_q <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
            if (widx == WIDX_W'(IDX_WLO))  wlo_q  <= bus_wdata;
            if (widx == WIDX_W'(IDX_WHI))  whi_q  <= bus_wdata;
        end
    end

    // Purpose: read multiplexer
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (widx)
                WIDX_W'(IDX_RAND):  bus_rdata = lfsr_state;
                WIDX_W'(IDX_CTRL):  bus_rdata = DATA_W'(ctrl_q);
                WIDX_W'(IDX_WLO):   bus_rdata = wlo_q;
                WIDX_W'(IDX_WHI):   bus_rdata = whi_q;
                WIDX_W'(IDX_RLO):   bus_rdata = swap_lo;
                WIDX_W'(IDX_RHI):   bus_rdata = swap_hi;
                WIDX_W'(IDX_META):  bus_rdata = meta_val;
                WIDX_W'(IDX_NOISE): bus_rdata = noise_val;
                default:            bus_rdata = '0;
            endcase
        end
    end

    assign ctrl    = ctrl_q;
    assign wbuf_lo = wlo_q;
    assign wbuf_hi = whi_q;
endmodule

// File: rtl/rng_swap_periph.sv
// Module: top of the random generator / byte-swap peripheral.
// Assumes a single clock, synchronous active-low reset, combinational reads.
module rng_swap_periph
    import rsw_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [31:0]       meta_val_i,
    input  logic [31:0]       noise_val_i,
    output logic              meta_fast_o,
    output logic              noise_en_o,
    output logic              meta_en_o
);
    ctrl_t             ctrl;
    logic [DATA_W-1:0] lfsr_state;
    logic [DATA_W-1:0] wbuf_lo;
    logic [DATA_W-1:0] wbuf_hi;
    logic [DATA_W-1:0] swap_lo;
    logic [DATA_W-1:0] swap_hi;
    logic              seed_load;
    logic              rand_read;
    logic              lfsr_step;
    logic              mode_read_step;

    assign mode_read_step = ctrl.step_on_read;

    // Purpose: step every clock, or only on a read of the generator word
    always_comb begin
        lfsr_step = mode_read_step ? rand_read : 1'b1;
    end

    rsw_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .lfsr_state (lfsr_state),
        .swap_lo    (swap_lo),
        .swap_hi    (swap_hi),
        .meta_val   (meta_val_i),
        .noise_val  (noise_val_i),
        .ctrl       (ctrl),
        .wbuf_lo    (wbuf_lo),
        .wbuf_hi    (wbuf_hi),
        .seed_load  (seed_load),
        .rand_read  (rand_read)
    );

    rsw_lfsr #(
        .W        (DATA_W),
        .MASK     (TAP_MASK),
        .FALLBACK (SEED_FALLBACK)
    ) u_lfsr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (seed_load),
        .load_val (bus_wdata),
        .step     (lfsr_step),
        .state    (lfsr_state)
    );

    rsw_swap #(.W(DATA_W)) u_swap (
        .wr_lo  (wbuf_lo),
        .wr_hi  (wbuf_hi),
        .swap64 (ctrl.swap64),
        .rd_lo  (swap_lo),
        .rd_hi  (swap_hi)
    );

    // Purpose: source controls straight from the control register
    always_comb begin
        meta_fast_o = ctrl.meta_fast;
        noise_en_o  = ctrl.noise_en;
        meta_en_o   = ctrl.meta_en;
    end
endmodule

// File: rtl/rsw_checker.sv
// Module: temporal checks for rng_swap_periph, attached by bind.
// Assumes strobes and address are stable around each rising edge.
module rsw_checker #(
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       meta_val_i,
    input logic              meta_en_o,
    input logic              mode,
    input logic [31:0]       lfsr_state
);
    logic [ADDR_W-3:0] widx;
    logic              wr0;
    logic              rd0;
    assign widx = bus_addr[ADDR_W-1:2];
    assign wr0  = bus_wr && (widx == '0);
    assign rd0  = bus_rd && (widx == '0);

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != 32'h0);

    // R4
    read_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !rd0 && !wr0) |=> $stable(lfsr_state));

    // R3
    free_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !wr0) |=> lfsr_state ==
            (($past(lfsr_state) >> 1) ^ ($past(lfsr_state[0]) ? 32'h8020_0003 : 32'h0)));

    // R5
    seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr0 && bus_wdata != 32'h0) |=> lfsr_state == $past(bus_wdata));

    // R8
    meta_en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && widx == 1) |=> meta_en_o == $past(bus_wdata[4]));

    // R12
    meta_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx == 6) |-> bus_rdata == meta_val_i);

    // R13
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && widx >= 8) |-> bus_rdata == 32'h0);
endmodule

bind rng_swap_periph rsw_checker #(.ADDR_W(ADDR_W)) u_rsw_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .meta_val_i (meta_val_i),
    .meta_en_o  (meta_en_o),
    .mode       (mode_read_step),
    .lfsr_state (lfsr_state)
);

// File: tb/test_rng_swap_periph.sv
`timescale 1ns/1ps
module test_rng_swap_periph;
    localparam logic [31:0] FALLBACK = 32'h5EED_0001;
    localparam logic [31:0] MASK     = 32'h8020_0003;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] meta_val_i = 32'h1234_5678;
    logic [31:0] noise_val_i = 32'h9ABC_DEF0;
    logic        meta_fast_o, noise_en_o, meta_en_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rng_swap_periph i_rng_swap_periph (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .meta_val_i(meta_val_i), .noise_val_i(noise_val_i),
        .meta_fast_o(meta_fast_o), .noise_en_o(noise_en_o), .meta_en_o(meta_en_o)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? MASK : 32'h0);
    endfunction

    function automatic logic [31:0] brev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        #1 bus_rd = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] exp;
        logic [31:0] lo_pat [4];
        logic [31:0] hi_pat [4];
        lo_pat = '{32'h0302_0100, 32'hDEAD_BEEF, 32'hFFFF_0000, 32'hA5C3_1E87};
        hi_pat = '{32'h0706_0504, 32'h0123_4567, 32'h00FF_00FF, 32'h5A3C_E178};

        // R1: values while reset is held
        rd(6'h00, v); check("R1 lfsr in reset", v, FALLBACK);
        rd(6'h04, v); check("R1 ctrl in reset", v, 32'h0);
        rd(6'h08, v); check("R1 wbuf lo in reset", v, 32'h0);
        rd(6'h0C, v); check("R1 wbuf hi in reset", v, 32'h0);
        check("R1 outputs in reset", {29'h0, meta_fast_o, noise_en_o, meta_en_o}, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R7 R8: full sweep of control values, upper bits set on the write
        for (int c = 0; c < 64; c++) begin
            wr(6'h04, 32'hFFFF_FFC0 | c);
            rd(6'h04, v); check("R7 ctrl readback", v, 32'(c));
            check("R8 source outputs", {29'h0, meta_fast_o, noise_en_o, meta_en_o},
                  {29'h0, 1'(c >> 2), 1'(c >> 3), 1'(c >> 4)});
        end

        // R9 R10 R11: byte reversal in both modes
        for (int p = 0; p < 4; p++) begin
            wr(6'h08, lo_pat[p]);
            wr(6'h0C, hi_pat[p]);
            rd(6'h08, v); check("R9 wbuf lo", v, lo_pat[p]);
            rd(6'h0C, v); check("R9 wbuf hi", v, hi_pat[p]);
            wr(6'h04, 32'h0);
            rd(6'h10, v); check("R10 rlo swap32", v, brev(lo_pat[p]));
            rd(6'h14, v); check("R10 rhi", v, brev(lo_pat[p]));
            wr(6'h04, 32'h2);
            rd(6'h10, v); check("R11 rlo swap64", v, brev(hi_pat[p]));
            rd(6'h14, v); check("R11 rhi swap64", v, brev(lo_pat[p]));
        end

        // R12: pass-through and ignored writes to read-only words
        wr(6'h04, 32'h15);
        wr(6'h18, 32'hFFFF_FFFF);
        wr(6'h1C, 32'hFFFF_FFFF);
        wr(6'h10, 32'h0);
        wr(6'h14, 32'h0);
        rd(6'h18, v); check("R12 meta pass", v, 32'h1234_5678);
        rd(6'h1C, v); check("R12 noise pass", v, 32'h9ABC_DEF0);
        @(negedge clk); meta_val_i = 32'hCAFE_F00D; noise_val_i = 32'h0BAD_C0DE;
        rd(6'h18, v); check("R12 meta pass 2", v, 32'hCAFE_F00D);
        rd(6'h1C, v); check("R12 noise pass 2", v, 32'h0BAD_C0DE);
        rd(6'h04, v); check("R12 ctrl untouched", v, 32'h15);
        rd(6'h08, v); check("R12 wbuf lo untouched", v, lo_pat[3]);
        rd(6'h0C, v); check("R12 wbuf hi untouched", v, hi_pat[3]);

        // R13: unmapped offsets read zero and swallow writes
        for (int a = 8; a < 16; a++) begin
            wr(6'(a * 4), 32'hFFFF_FFFF);
            rd(6'(a * 4), v); check("R13 unmapped read", v, 32'h0);
        end
        rd(6'h04, v); check("R13 ctrl untouched", v, 32'h15);
        rd(6'h08, v); check("R13 wbuf lo untouched", v, lo_pat[3]);

        // R2 R3 R5: free-running steps from several seeds
        wr(6'h04, 32'h0);
        for (int s = 0; s < 3; s++) begin
            logic [31:0] seed;
            seed = (s == 0) ? 32'h0000_0001 : (s == 1) ? 32'h8000_0000 : 32'hC0DE_1234;
            wr(6'h00, seed);
            exp = seed;
            for (int k = 0; k < 40; k++) begin
                rd(6'h00, v); check("R3 R2 free-run sequence", v, exp);
                exp = nxt(exp);
            end
        end
        // R5: seed loaded even though a free-run step competes
        wr(6'h00, 32'h1357_9BDF);
        rd(6'h00, v); check("R5 seed over step", v, 32'h1357_9BDF);

        // R6: zero seed replaced by the fallback constant
        wr(6'h00, 32'h0);
        rd(6'h00, v); check("R6 zero seed", v, FALLBACK);

        // R4: read-advance mode
        wr(6'h04, 32'h1);
        wr(6'h00, 32'hBEEF_0001);
        exp = 32'hBEEF_0001;
        for (int k = 0; k < 30; k++) begin
            rd(6'h00, v); check("R4 read-advance value", v, exp);
            exp = nxt(exp);
            rd(6'h04, v);
            rd(6'h18, v);
            repeat (3) @(negedge clk);
        end
        rd(6'h00, v); check("R4 no step on other reads", v, exp);
        // R6 in read-advance mode
        wr(6'h00, 32'h0);
        rd(6'h00, v); check("R6 zero seed in read mode", v, FALLBACK);
        rd(6'h00, v); check("R4 step after read", v, nxt(FALLBACK));

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule